// File: doc/BRIEF.md
# Receive Buffer Credit Tracker

This block keeps a running count of the receive buffers that software has handed to one receive DMA channel, and turns that count into a pause request for the link. Software adds credits through a buffer-allocation register. Usually it writes a count of one each time it re-arms a descriptor. Setting the top data bit loads the counter with an absolute value instead of adding to it. The receive engine pulses a strobe each time it consumes a descriptor, and every pulse removes one credit.

Pause uses hysteresis. Two thresholds, low and high, are programmed separately, and software usually sets them to one third and two thirds of the ring size. The internal pause state is set when the credit falls to or below the low threshold. It is cleared only when the credit climbs to or above the high threshold. A channel flow-control enable gates whether that state reaches the pause output. The state keeps tracking the credit while the output is gated off.

Top module: `rxbuf_credit_tracker`

## Requirements
- R1: A register write with `reg_sel` = 0 and bit `DW-1` of `reg_wdata` clear adds `reg_wdata[CW-1:0]` to the credit, and the result is visible on `credit` after that clock edge.
- R2: A register write with `reg_sel` = 0 and bit `DW-1` set loads the credit with `reg_wdata[CW-1:0]`. A consume strobe in the same cycle is ignored.
- R3: Each cycle with `consume` high and no allocation write lowers the credit by one. When the credit is zero it stays at zero.
- R4: An additive allocation write and a consume strobe in the same cycle change the credit by the written count minus one.
- R5: An addition that would pass 2^CW-1 leaves the credit at 2^CW-1.
- R6: A write with `reg_sel` = 1 sets the low threshold and a write with `reg_sel` = 2 sets the high threshold, each from `reg_wdata[CW-1:0]`. A new threshold is compared against the credit starting on the clock edge after the write.
- R7: The pause state is set on an edge where the new credit is at or below the low threshold. It is cleared on an edge where the new credit is at or above the high threshold and above the low threshold. Otherwise it keeps its previous value.
- R8: `pause` equals the pause state when `fc_enable` is high and is 0 when `fc_enable` is low. The pause state keeps tracking the credit while `fc_enable` is low.
- R9: While reset is held and afterwards until the first write or strobe, the credit is 0, both thresholds are 0, and the pause state is set.
- R10: A register write with `reg_sel` = 3 changes neither the credit nor the pause state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 allocation, 1 low threshold, 2 high threshold |
| reg_wdata | input | DW | Write data. Bit DW-1 is the force flag and bits CW-1:0 are the value |
| consume | input | 1 | One pulse per descriptor consumed by the receive engine |
| fc_enable | input | 1 | Channel flow-control enable |
| credit | output | CW | Current buffer credit |
| pause | output | 1 | Backpressure request |

## Verification
A corrupted credit register shows up on `credit` at the very next edge, because every write and strobe is checked one cycle later against a count the bench keeps itself. A wrong pause state shows only when the hysteresis is tested from both sides. For that reason the credit is walked down through the low threshold, back up through the gap between the thresholds, and across the high threshold. The bench also checks that the pause state survives a window with flow control disabled, and that it appears on `pause` in the same cycle the enable returns.

// File: rtl/rxbuf_credit_tracker.sv
module rxbuf_credit_tracker #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          consume,
  input  logic          fc_enable,
  output logic [CW-1:0] credit,
  output logic          pause
);
  localparam logic [1:0]    SEL_ALLOC = 2'd0;
  localparam logic [1:0]    SEL_LO    = 2'd1;
  localparam logic [1:0]    SEL_HI    = 2'd2;
  localparam logic [CW+1:0] CMAX      = {2'b00, {CW{1'b1}}};
  localparam logic [CW+1:0] ONE       = {{(CW+1){1'b0}}, 1'b1};

  logic [CW-1:0] cr_q, lo_q, hi_q, cr_nxt, field;
  logic          hold_q, hold_nxt;
  logic          wr_force, wr_add;
  logic [CW+1:0] sum, sum_dec;
  logic          unused_hi;

  assign field     = reg_wdata[CW-1:0];
  assign unused_hi = ^reg_wdata[DW-2:CW];
  assign wr_force  = reg_wr && reg_sel == SEL_ALLOC &&  reg_wdata[DW-1];
  assign wr_add    = reg_wr && reg_sel == SEL_ALLOC && !reg_wdata[DW-1];

  assign sum     = {2'b00, cr_q} + (wr_add ? {2'b00, field} : '0);
  assign sum_dec = (consume && sum != '0) ? sum - ONE : sum;

  always_comb begin
    if (wr_force)          cr_nxt = field;
    else if (sum_dec > CMAX) cr_nxt = {CW{1'b1}};
    else                   cr_nxt = sum_dec[CW-1:0];
  end

  always_comb begin
    if (cr_nxt <= lo_q)      hold_nxt = 1'b1;
    else if (cr_nxt >= hi_q) hold_nxt = 1'b0;
    else                     hold_nxt = hold_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      hold_q <= 1'b1;
    end else begin
      cr_q   <= cr_nxt;
      hold_q <= hold_nxt;
      if (reg_wr && reg_sel == SEL_LO) lo_q <= field;
      if (reg_wr && reg_sel == SEL_HI) hi_q <= field;
    end
  end

  assign credit = cr_q;
  assign pause  = fc_enable & hold_q;

  p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_add && !consume && ({1'b0, credit} + {1'b0, field}) <= {1'b0, {CW{1'b1}}})
    |=> credit == $past(credit) + $past(field));

  p_force_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_force |=> credit == $past(field));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !reg_wr && credit != '0) |=> credit == $past(credit) - 1'b1);

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !reg_wr && credit == '0) |=> credit == '0);

  p_low_pause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_enable && credit <= lo_q && $stable(lo_q)) |-> pause);

  p_stay_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_enable && $past(pause) && credit < hi_q && $stable(hi_q)) |-> pause);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (credit >= hi_q && credit > lo_q && $stable(hi_q) && $stable(lo_q)) |-> !pause);

  p_idle_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && !consume) |=> $stable(credit));
endmodule

// File: tb/rxbuf_credit_tracker_test.sv
`timescale 1ns/1ps
module rxbuf_credit_tracker_test;
  typedef struct {
    int    cr;
    bit    pz;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        consume = 1'b0;
  logic        fc_enable = 1'b1;
  logic [15:0] credit;
  logic        pause;

  exp_t sb[$];
  int   nchk = 0, nfail = 0;
  int   m_cr = 0, m_lo = 0, m_hi = 0;
  bit   m_hold = 1'b1;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rxbuf_credit_tracker #(.DW(32), .CW(16)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .consume(consume), .fc_enable(fc_enable),
    .credit(credit), .pause(pause)
  );

  task automatic step(input bit wr, input bit [1:0] sel, input bit [31:0] d,
                      input bit cons, input bit fc, input string tag);
    int s;
    exp_t e;
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = d; consume = cons; fc_enable = fc;
    s = m_cr + ((wr && sel == 2'd0 && !d[31]) ? int'(d[15:0]) : 0);
    if (cons && s > 0) s = s - 1;
    if (s > 65535) s = 65535;
    if (wr && sel == 2'd0 && d[31]) s = int'(d[15:0]);
    if (s <= m_lo) m_hold = 1'b1;
    else if (s >= m_hi) m_hold = 1'b0;
    if (wr && sel == 2'd1) m_lo = int'(d[15:0]);
    if (wr && sel == 2'd2) m_hi = int'(d[15:0]);
    m_cr = s;
    @(posedge clk);
    e.cr = m_cr; e.pz = fc & m_hold; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      nchk++;
      if (int'(credit) != e.cr || pause != e.pz) begin
        nfail++;
        $display("FAIL %s: credit=%0d pause=%0b expected credit=%0d pause=%0b",
                 e.tag, credit, pause, e.cr, e.pz);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    nchk++;
    if (credit != 16'd0 || pause != 1'b1) begin
      nfail++;
      $display("FAIL R9: credit=%0d pause=%0b expected credit=0 pause=1", credit, pause);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 1, "R9");
    step(1, 1, 32'd4, 0, 1, "R6");
    step(1, 2, 32'd8, 0, 1, "R6");
    step(1, 0, 32'd1, 0, 1, "R1");
    step(1, 0, 32'h8000_0014, 0, 1, "R2");
    step(1, 0, 32'd5, 0, 1, "R1");
    for (int i = 0; i < 21; i++) step(0, 0, 0, 1, 1, "R3");
    step(1, 0, 32'd3, 0, 1, "R7");
    step(1, 0, 32'd1, 0, 1, "R7");
    step(1, 3, 32'd100, 0, 1, "R10");
    step(1, 0, 32'd2, 1, 1, "R4");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 1, "R8");
    step(1, 0, 32'h8000_0002, 1, 1, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, "R3");
    step(1, 0, 32'h8000_FFFA, 0, 1, "R2");
    step(1, 0, 32'd10, 0, 1, "R5");
    step(1, 0, 32'd0, 1, 1, "R4");
    step(1, 1, 32'd65534, 0, 1, "R6");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    repeat (2) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule